// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block sits beside an analog-to-digital converter and watches every conversion result it is handed. It builds a high and a low 10-bit limit from two byte-sized register values each. It marks any result that lies strictly above the high limit or strictly below the low limit. Only indices whose bit is set in a 16-bit enable mask are watched. An out-of-band result on such an index sets that index's bit in a sticky 16-bit status vector and sets a sticky global watchdog flag.

The index is the converter channel number in normal operation. In buffered mode it is the buffer-entry number. Watching happens only while the converter runs in continuous mode. An interrupt request is raised from the watchdog flag when the watchdog interrupt is enabled. It is also raised from a sticky end-of-conversion flag when that interrupt is enabled. Software clears status bits by writing zeros into the byte half of the status that holds them. It clears the flags with dedicated clear strobes. Sequencing of the converter itself is not part of this block.

Top module: `awd_monitor`

## Requirements
- R1: After reset the status vector is 0, the watchdog flag is 0 and the interrupt request is 0.
- R2: The high limit is {hi_ub, hi_lb}, with the upper byte giving bits 9:2 and the 2-bit lower part giving bits 1:0; the low limit is built the same way from lo_ub and lo_lb. For example, 0xCC with 3 gives 819, and 0x33 with 1 gives 205.
- R3: A valid result greater than the high limit or less than the low limit is out of band. A result equal to either limit, or between them, changes nothing.
- R4: An out-of-band result is recorded only when the enable bit for its index is set. The enable mask is {en_hi, en_lo}, so bit i enables index i.
- R5: With buf_mode 0 the index is res_chan; with buf_mode 1 it is res_slot.
- R6: With cont_mode 0 no result changes the status or the flag.
- R7: An out-of-band result sets status bit i and awd_flag on the clock edge that samples res_valid, and both then hold. A write with stat_we[0] loads the value stat_wdata into status bits 7:0, and a write with stat_we[1] loads it into bits 15:8. In that value, a 0 bit clears the status bit and a 1 bit keeps it. flag_clr clears awd_flag.
- R8: When a set and a clear of the same status bit, of awd_flag, or of the end-of-conversion flag fall in the same cycle, the set wins.
- R9: irq is 1 exactly when (awd_flag and awd_ie) or (end-of-conversion flag and eoc_ie). The end-of-conversion flag is set by eoc_evt and cleared by eoc_clr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result-valid strobe |
| res_data | input | 10 | Conversion result |
| res_chan | input | 4 | Channel of the result |
| res_slot | input | 4 | Buffer entry of the result |
| cont_mode | input | 1 | Converter in continuous mode |
| buf_mode | input | 1 | Buffered mode: index by buffer entry |
| hi_ub | input | 8 | High limit bits 9:2 |
| hi_lb | input | 2 | High limit bits 1:0 |
| lo_ub | input | 8 | Low limit bits 9:2 |
| lo_lb | input | 2 | Low limit bits 1:0 |
| en_lo | input | 8 | Enable mask bits 7:0 |
| en_hi | input | 8 | Enable mask bits 15:8 |
| stat_we | input | 2 | Status half write strobes (0: bits 7:0, 1: bits 15:8) |
| stat_wdata | input | 8 | Status write data (0 clears, 1 keeps) |
| flag_clr | input | 1 | Clear watchdog flag |
| eoc_evt | input | 1 | End-of-conversion event |
| eoc_clr | input | 1 | Clear end-of-conversion flag |
| awd_ie | input | 1 | Watchdog interrupt enable |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| awd_status | output | 16 | Sticky per-index out-of-band status |
| awd_flag | output | 1 | Sticky global watchdog flag |
| irq | output | 1 | Interrupt request |

## Verification
Recording an out-of-band result and a software clear can land in the same cycle. This can happen on a status bit, on the global flag, or on the end-of-conversion flag. The bench provokes the collision by driving an out-of-band result on an enabled index together with an all-zero write to both status halves and a flag clear. It also pulses eoc_evt together with eoc_clr. A correct result leaves the index bit set, the flag set, and irq asserted after the edge, with every other status bit cleared.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 4;

  typedef struct packed {
    logic above;
    logic below;
  } band_t;
endpackage

// File: rtl/awd_thresh.sv
module awd_thresh
  import awd_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned LW = DW - BW
) (
  input  logic [BW-1:0] hi_ub,
  input  logic [LW-1:0] hi_lb,
  input  logic [BW-1:0] lo_ub,
  input  logic [LW-1:0] lo_lb,
  input  logic [DW-1:0] data,
  output band_t         cls
);
  logic [DW-1:0] hi_lim;
  logic [DW-1:0] lo_lim;

  always_comb begin
    hi_lim    = {hi_ub, hi_lb};
    lo_lim    = {lo_ub, lo_lb};
    cls.above = (data > hi_lim);
    cls.below = (data < lo_lim);
  end
endmodule

// File: rtl/awd_sticky.sv
module awd_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;
  logic q_ce;

  always_comb begin
    q_ce  = set | clr;
    q_nxt = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_ce) q <= q_nxt;
  end
endmodule

// File: rtl/awd_status.sv
module awd_status
  import awd_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned BW  = BYTE_W,
  localparam int unsigned HALVES = NCH / BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    set_vec,
  input  logic [HALVES-1:0] we,
  input  logic [BW-1:0]     wdata,
  output logic [NCH-1:0]    status
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [BW-1:0] keep;
    logic [BW-1:0] nxt;
    logic          ce;

    always_comb begin
      keep = we[h] ? wdata : {BW{1'b1}};
      nxt  = (status[h*BW +: BW] & keep) | set_vec[h*BW +: BW];
      ce   = we[h] | (|set_vec[h*BW +: BW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  status[h*BW +: BW] <= '0;
      else if (ce) status[h*BW +: BW] <= nxt;
    end
  end
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
  import awd_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned IW = IDX_W,
  localparam int unsigned LW = DW - BW,
  localparam int unsigned NCH = 1 << IW,
  localparam int unsigned HALVES = NCH / BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DW-1:0]     res_data,
  input  logic [IW-1:0]     res_chan,
  input  logic [IW-1:0]     res_slot,
  input  logic              cont_mode,
  input  logic              buf_mode,
  input  logic [BW-1:0]     hi_ub,
  input  logic [LW-1:0]     hi_lb,
  input  logic [BW-1:0]     lo_ub,
  input  logic [LW-1:0]     lo_lb,
  input  logic [BW-1:0]     en_lo,
  input  logic [BW-1:0]     en_hi,
  input  logic [HALVES-1:0] stat_we,
  input  logic [BW-1:0]     stat_wdata,
  input  logic              flag_clr,
  input  logic              eoc_evt,
  input  logic              eoc_clr,
  input  logic              awd_ie,
  input  logic              eoc_ie,
  output logic [NCH-1:0]    awd_status,
  output logic              awd_flag,
  output logic              irq
);
  band_t          cls;
  logic [IW-1:0]  idx;
  logic [NCH-1:0] sel;
  logic [NCH-1:0] en_mask;
  logic [NCH-1:0] set_vec;
  logic           out_band;
  logic           eoc_flag;

  awd_thresh #(.DW(DW), .BW(BW)) u_thresh (
    .hi_ub (hi_ub),
    .hi_lb (hi_lb),
    .lo_ub (lo_ub),
    .lo_lb (lo_lb),
    .data  (res_data),
    .cls   (cls)
  );

  always_comb begin
    idx      = buf_mode ? res_slot : res_chan;
    sel      = {{(NCH-1){1'b0}}, 1'b1} << idx;
    en_mask  = {en_hi, en_lo};
    out_band = res_valid & cont_mode & (cls.above | cls.below);
    set_vec  = out_band ? (sel & en_mask) : '0;
  end

  awd_status #(.NCH(NCH), .BW(BW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .we      (stat_we),
    .wdata   (stat_wdata),
    .status  (awd_status)
  );

  awd_sticky u_awd_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (|set_vec),
    .clr   (flag_clr),
    .q     (awd_flag)
  );

  awd_sticky u_eoc_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (eoc_evt),
    .clr   (eoc_clr),
    .q     (eoc_flag)
  );

  always_comb irq = (awd_flag & awd_ie) | (eoc_flag & eoc_ie);
endmodule

// File: rtl/awd_monitor_chk.sv
module awd_monitor_chk #(
  parameter int unsigned DW = 10,
  parameter int unsigned BW = 8,
  parameter int unsigned IW = 4,
  localparam int unsigned LW = DW - BW,
  localparam int unsigned NCH = 1 << IW,
  localparam int unsigned HALVES = NCH / BW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [DW-1:0]     res_data,
  input logic [IW-1:0]     res_chan,
  input logic [IW-1:0]     res_slot,
  input logic              cont_mode,
  input logic              buf_mode,
  input logic [BW-1:0]     hi_ub,
  input logic [LW-1:0]     hi_lb,
  input logic [BW-1:0]     lo_ub,
  input logic [LW-1:0]     lo_lb,
  input logic [BW-1:0]     en_lo,
  input logic [BW-1:0]     en_hi,
  input logic [HALVES-1:0] stat_we,
  input logic              flag_clr,
  input logic              awd_ie,
  input logic              eoc_ie,
  input logic [NCH-1:0]    awd_status,
  input logic              awd_flag,
  input logic              irq
);
  logic [DW-1:0]  hv;
  logic [DW-1:0]  lv;
  logic [IW-1:0]  ix;
  logic [NCH-1:0] em;
  logic           no_clr;
  logic           bad;

  always_comb begin
    hv     = {hi_ub, hi_lb};
    lv     = {lo_ub, lo_lb};
    ix     = buf_mode ? res_slot : res_chan;
    em     = {en_hi, en_lo};
    no_clr = (stat_we == '0) && !flag_clr;
    bad    = res_valid && cont_mode && ((res_data > hv) || (res_data < lv)) && em[ix];
  end

  AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cont_mode && no_clr) |=> ($stable(awd_status) && $stable(awd_flag))); // R6

  AST_INBAND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_data <= hv && res_data >= lv && no_clr) |=> ($stable(awd_status) && $stable(awd_flag))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (awd_flag && awd_status != '0)); // R8

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    no_clr |=> ((awd_status & $past(awd_status)) == $past(awd_status))); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!awd_ie && !eoc_ie) |-> !irq); // R9
endmodule

bind awd_monitor awd_monitor_chk #(.DW(DW), .BW(BW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_chan   (res_chan),
  .res_slot   (res_slot),
  .cont_mode  (cont_mode),
  .buf_mode   (buf_mode),
  .hi_ub      (hi_ub),
  .hi_lb      (hi_lb),
  .lo_ub      (lo_ub),
  .lo_lb      (lo_lb),
  .en_lo      (en_lo),
  .en_hi      (en_hi),
  .stat_we    (stat_we),
  .flag_clr   (flag_clr),
  .awd_ie     (awd_ie),
  .eoc_ie     (eoc_ie),
  .awd_status (awd_status),
  .awd_flag   (awd_flag),
  .irq        (irq)
);

// File: tb/tb_awd_monitor.sv
`timescale 1ns/1ps
module tb_awd_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [9:0]  res_data;
  logic [3:0]  res_chan, res_slot;
  logic        cont_mode, buf_mode;
  logic [7:0]  hi_ub, lo_ub, en_lo, en_hi, stat_wdata;
  logic [1:0]  hi_lb, lo_lb, stat_we;
  logic        flag_clr, eoc_evt, eoc_clr, awd_ie, eoc_ie;
  logic [15:0] awd_status;
  logic        awd_flag, irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  awd_monitor dut (.*);

  // fields: cont, buf, chan, slot, data, expect hit, expected index
  localparam logic [24:0] VEC [12] = '{
    {1'b1, 1'b0, 4'd3,  4'd0,  10'd820,  1'b1, 4'd3},
    {1'b1, 1'b0, 4'd3,  4'd0,  10'd819,  1'b0, 4'd0},
    {1'b1, 1'b0, 4'd3,  4'd0,  10'd205,  1'b0, 4'd0},
    {1'b1, 1'b0, 4'd3,  4'd0,  10'd204,  1'b1, 4'd3},
    {1'b1, 1'b0, 4'd14, 4'd0,  10'd1000, 1'b0, 4'd0},
    {1'b1, 1'b1, 4'd14, 4'd5,  10'd1000, 1'b1, 4'd5},
    {1'b1, 1'b1, 4'd2,  4'd14, 10'd0,    1'b0, 4'd0},
    {1'b0, 1'b0, 4'd3,  4'd0,  10'd1023, 1'b0, 4'd0},
    {1'b1, 1'b0, 4'd15, 4'd0,  10'd0,    1'b1, 4'd15},
    {1'b1, 1'b0, 4'd0,  4'd0,  10'd500,  1'b0, 4'd0},
    {1'b1, 1'b1, 4'd0,  4'd9,  10'd1023, 1'b1, 4'd9},
    {1'b1, 1'b0, 4'd8,  4'd0,  10'd1023, 1'b1, 4'd8}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    res_valid = 0; stat_we = 0; flag_clr = 0; eoc_evt = 0; eoc_clr = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic clear_all();
    stat_we = 2'b11; stat_wdata = 8'h00; flag_clr = 1; eoc_clr = 1; step();
  endtask

  task automatic result(input bit c, input bit b, input logic [3:0] ch,
                        input logic [3:0] sl, input logic [9:0] d);
    cont_mode = c; buf_mode = b; res_chan = ch; res_slot = sl;
    res_data = d; res_valid = 1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; res_data = 0; res_chan = 0; res_slot = 0;
    cont_mode = 1; buf_mode = 0; stat_wdata = 0;
    hi_ub = 8'hCC; hi_lb = 2'd3; lo_ub = 8'h33; lo_lb = 2'd1; // R2: 819 / 205
    en_lo = 8'hFF; en_hi = 8'hBF;                              // index 14 disabled
    awd_ie = 1; eoc_ie = 1;
    repeat (3) @(negedge clk);
    chk("R1 status", awd_status, 16'h0);
    chk("R1 flag", {15'b0, awd_flag}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    awd_ie = 0; eoc_ie = 0;

    // Vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 12; i++) begin
      logic [24:0] v;
      v = VEC[i];
      result(v[24], v[23], v[22:19], v[18:15], v[14:5]);
      step();
      chk($sformatf("R3 R4 R5 R6 vector %0d status", i), awd_status,
          v[4] ? (16'h1 << v[3:0]) : 16'h0);
      chk($sformatf("R3 R4 R5 R6 vector %0d flag", i), {15'b0, awd_flag}, {15'b0, v[4]});
      clear_all();
    end

    // R7 sticky accumulation and partial clear
    result(1, 0, 4'd3, 0, 10'd1023); step();
    result(1, 0, 4'd8, 0, 10'd0);    step();
    chk("R7 accumulate", awd_status, 16'h0108);
    stat_we = 2'b01; stat_wdata = 8'hF7; step();
    chk("R7 low half clear", awd_status, 16'h0100);
    chk("R7 flag held", {15'b0, awd_flag}, 16'h1);
    flag_clr = 1; step();
    chk("R7 flag cleared", {15'b0, awd_flag}, 16'h0);
    chk("R7 status kept after flag clear", awd_status, 16'h0100);
    stat_we = 2'b10; stat_wdata = 8'h00; step();
    chk("R7 high half clear", awd_status, 16'h0);

    // R8 set beats clear in the same cycle
    result(1, 0, 4'd6, 0, 10'd1023); step();
    result(1, 0, 4'd1, 0, 10'd1000);
    stat_we = 2'b11; stat_wdata = 8'h00; flag_clr = 1; step();
    chk("R8 status set wins", awd_status, 16'h0002);
    chk("R8 flag set wins", {15'b0, awd_flag}, 16'h1);

    // R9 interrupt gating
    chk("R9 irq masked", {15'b0, irq}, 16'h0);
    awd_ie = 1; #1;
    chk("R9 irq from watchdog", {15'b0, irq}, 16'h1);
    flag_clr = 1; step();
    chk("R9 irq drops on flag clear", {15'b0, irq}, 16'h0);
    eoc_evt = 1; step();
    chk("R9 eoc masked", {15'b0, irq}, 16'h0);
    eoc_ie = 1; #1;
    chk("R9 irq from eoc", {15'b0, irq}, 16'h1);
    eoc_clr = 1; step();
    chk("R9 eoc cleared", {15'b0, irq}, 16'h0);
    eoc_evt = 1; eoc_clr = 1; step();
    chk("R8 eoc set wins", {15'b0, irq}, 16'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule